// File: doc/BRIEF.md
# CAN Mailbox Event Flag Unit

This block holds the per-mailbox status vectors and the summary interrupt flags of a CAN controller with 32 mailboxes. The frame engine reports each finished activity as a one-cycle pulse on a per-mailbox vector: data frame received, remote frame received, message overrun or overwrite, transmission completed, and transmission aborted. The block turns these pulses into sticky status bits and into four interrupt flag bits. Software reads and clears the bits through a plain 16-bit register port. Software also writes transmit and cancel requests and a per-mailbox interrupt mask through the same port.

The mask acts only on the interrupt flags. A masked mailbox still records every receive event, still has its transmit request and cancel bits cleared, and still has its acknowledge bits set. The only effect of the mask is that this mailbox cannot raise an interrupt flag. The interrupt output is high while any interrupt flag is set.

Each 32-bit vector appears as two 16-bit registers. The low part always holds mailboxes 15..0 and the high part always holds mailboxes 31..16. Reads are combinational from the address. Writes take effect on the rising clock edge.

Top module: `mbx_event_flags`

## Requirements
- R1: After reset, every status vector, the mask and the interrupt flags read 0, and `irq_o` is low.
- R2: A data-receive pulse sets that mailbox's receive-pending bit, and an overrun pulse sets its unread-message bit. Writing 1 to one of these bits clears it. Writing 0 leaves it unchanged.
- R3: A remote-receive pulse sets that mailbox's remote-pending bit. The bit clears only on a write of 1. At address 3, bits 15..0 are mailboxes 31..16. At address 2, bits 15..0 are mailboxes 15..0.
- R4: Writing 1 to a transmit-request bit or a cancel bit sets that bit, and writing 0 leaves it unchanged. A transmit-success pulse or an abort pulse for that mailbox clears both of its bits.
- R5: A transmit-success pulse sets the mailbox's transmit-ack bit, and an abort pulse sets its abort-ack bit. Both ack bits are write-1-to-clear.
- R6: An event on any unmasked mailbox sets an interrupt flag bit in the register at address 16:
  - bit 1 for a data frame received;
  - bit 2 for a remote frame received;
  - bit 9 for an overrun;
  - bit 8 for mailbox empty, which covers both transmit success and abort.
- R7: A mask bit of 1 stops that mailbox from setting interrupt flag bits 1, 2, 8 and 9. It leaves every status, request-clear and acknowledge update for that mailbox unchanged.
- R8: Interrupt flag bits are write-1-to-clear. `irq_o` is high exactly while at least one interrupt flag bit is set.
- R9: When a hardware set and a software write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R10: The mask registers read back exactly what was last written. Interrupt flag bits other than 1, 2, 8 and 9 always read 0. Addresses 17 and above read 0, and writes to them change nothing.
- R11: Address map, with the low part at the even address and the high part at the odd address:

  | Address | Register |
  |---|---|
  | 0/1 | receive-pending |
  | 2/3 | remote-pending |
  | 4/5 | unread-message |
  | 6/7 | transmit-request |
  | 8/9 | cancel |
  | 10/11 | transmit-ack |
  | 12/13 | abort-ack |
  | 14/15 | mask |
  | 16 | interrupt flags |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data_ev_i | input | 32 | Data frame received, one bit per mailbox |
| rx_rmt_ev_i | input | 32 | Remote frame received, one bit per mailbox |
| rx_ovr_ev_i | input | 32 | Overrun or overwrite, one bit per mailbox |
| tx_ok_ev_i | input | 32 | Transmission succeeded, one bit per mailbox |
| tx_abort_ev_i | input | 32 | Transmission aborted, one bit per mailbox |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | 5 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for `bus_addr_i` |
| irq_o | output | 1 | Interrupt request |

## Verification
The embedded assertions check the following on every cycle:
- A set pulse always lands in its sticky bit, even when a clear hits the same bit in that cycle.
- A status bit never drops unless a 1 was written to it.
- A transmit completion or abort always clears that mailbox's request and cancel bits.
- Masked events never raise interrupt flag bits 1 or 8.
- An unmasked data event always raises `irq_o`.

Only the bench's scenarios can show the rest:
- the correct mapping of the two register halves;
- the read-back of the mask;
- reserved addresses and reserved interrupt bits reading 0;
- the full register contents after mixed random traffic.

// File: rtl/mbx_flags_pkg.sv
package mbx_flags_pkg;
   // Vector indexes. The address of a vector part is index * parts + part.
   localparam int VEC_RX   = 0;
   localparam int VEC_RMT  = 1;
   localparam int VEC_UNRD = 2;
   localparam int VEC_TXP  = 3;
   localparam int VEC_TXC  = 4;
   localparam int VEC_TXA  = 5;
   localparam int VEC_ABA  = 6;
   localparam int VEC_MASK = 7;
   localparam int NUM_VEC  = 8;

   // Interrupt flag bit positions.
   localparam int IRQ_DATA  = 1;
   localparam int IRQ_RMT   = 2;
   localparam int IRQ_EMPTY = 8;
   localparam int IRQ_OVR   = 9;
endpackage

// File: rtl/mbx_w1c_vec.sv
// Sticky flag vector: hardware set, software write-1 clear, set wins.
module mbx_w1c_vec #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] flags_o
);
   logic [W-1:0] flags_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= (flags_q & ~clr_i) | set_i;
   end

   assign flags_o = flags_q;

   // R9: a pulse always lands in its bit, even against a same-cycle clear
   assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_i) |=> ((flags_q & $past(set_i)) == $past(set_i)));

   // R2: a bit not written with 1 never drops
   assert_hold_without_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flags_q & $past(flags_q & ~clr_i)) == $past(flags_q & ~clr_i)));
endmodule

// File: rtl/mbx_tx_req_vec.sv
// Request vector: software write-1 set, hardware completion clear.
module mbx_tx_req_vec #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] req_i,
   input  logic [W-1:0] done_i,
   output logic [W-1:0] pend_o
);
   logic [W-1:0] pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~done_i) | req_i;
   end

   assign pend_o = pend_q;

   // R4: completion or abort without a new request leaves the bit clear
   assert_done_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (|(done_i & ~req_i)) |=> ((pend_q & $past(done_i & ~req_i)) == '0));
endmodule

// File: rtl/mbx_irq_flags.sv
// Summary interrupt flags, gated per mailbox by the mask.
module mbx_irq_flags
   import mbx_flags_pkg::*;
#(
   parameter int NUM_MBX = 32,
   parameter int REG_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_MBX-1:0] data_ev_i,
   input  logic [NUM_MBX-1:0] rmt_ev_i,
   input  logic [NUM_MBX-1:0] ovr_ev_i,
   input  logic [NUM_MBX-1:0] done_ev_i,
   input  logic [NUM_MBX-1:0] mask_i,
   input  logic [REG_W-1:0]   clr_i,
   output logic [REG_W-1:0]   flags_o,
   output logic               irq_o
);
   localparam logic [REG_W-1:0] IMPL =
      (REG_W'(1) << IRQ_DATA) | (REG_W'(1) << IRQ_RMT) |
      (REG_W'(1) << IRQ_EMPTY) | (REG_W'(1) << IRQ_OVR);

   logic [REG_W-1:0] flags_q;
   logic [REG_W-1:0] set_vec;

   always_comb begin
      set_vec            = '0;
      set_vec[IRQ_DATA]  = |(data_ev_i & ~mask_i);
      set_vec[IRQ_RMT]   = |(rmt_ev_i  & ~mask_i);
      set_vec[IRQ_EMPTY] = |(done_ev_i & ~mask_i);
      set_vec[IRQ_OVR]   = |(ovr_ev_i  & ~mask_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= ((flags_q & ~clr_i) | set_vec) & IMPL;
   end

   assign flags_o = flags_q;
   assign irq_o   = |flags_q;

   // R7: masked data events cannot raise the data flag
   assert_mask_blocks_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags_q[IRQ_DATA] && ((data_ev_i & ~mask_i) == '0)) |=> !flags_q[IRQ_DATA]);

   // R7: masked completions and aborts cannot raise the empty flag
   assert_mask_blocks_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags_q[IRQ_EMPTY] && ((done_ev_i & ~mask_i) == '0)) |=> !flags_q[IRQ_EMPTY]);

   // R6 and R9: an unmasked remote event raises its flag even against a clear
   assert_rmt_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|(rmt_ev_i & ~mask_i)) |=> flags_q[IRQ_RMT]);
endmodule

// File: rtl/mbx_event_flags.sv
module mbx_event_flags
   import mbx_flags_pkg::*;
#(
   parameter int NUM_MBX = 32,
   parameter int REG_W   = 16,
   parameter int ADDR_W  = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_MBX-1:0] rx_data_ev_i,
   input  logic [NUM_MBX-1:0] rx_rmt_ev_i,
   input  logic [NUM_MBX-1:0] rx_ovr_ev_i,
   input  logic [NUM_MBX-1:0] tx_ok_ev_i,
   input  logic [NUM_MBX-1:0] tx_abort_ev_i,
   input  logic               bus_wr_i,
   input  logic [ADDR_W-1:0]  bus_addr_i,
   input  logic [REG_W-1:0]   bus_wdata_i,
   output logic [REG_W-1:0]   bus_rdata_o,
   output logic               irq_o
);
   localparam int PARTS    = NUM_MBX / REG_W;
   localparam int IRQ_ADDR = NUM_VEC * PARTS;

   if (NUM_MBX % REG_W != 0) begin : g_chk_parts
      $error("NUM_MBX must be a multiple of REG_W");
   end
   if (REG_W <= IRQ_OVR) begin : g_chk_width
      $error("REG_W too narrow for interrupt flag positions");
   end
   if (IRQ_ADDR + 1 > (1 << ADDR_W)) begin : g_chk_addr
      $error("ADDR_W too small for the register map");
   end

   logic [NUM_VEC-1:0][NUM_MBX-1:0] vec_q;
   logic [VEC_MASK-1:0][NUM_MBX-1:0] wone;
   logic [VEC_MASK-1:0][NUM_MBX-1:0] hw_src;
   logic [NUM_MBX-1:0] tx_done;
   logic [NUM_MBX-1:0] mask_q;
   logic [REG_W-1:0]   irq_clr;
   logic [REG_W-1:0]   irq_flags;

   assign tx_done = tx_ok_ev_i | tx_abort_ev_i;

   // Hardware source per vector: a set pulse, or a clear for request vectors.
   assign hw_src[VEC_RX]   = rx_data_ev_i;
   assign hw_src[VEC_RMT]  = rx_rmt_ev_i;
   assign hw_src[VEC_UNRD] = rx_ovr_ev_i;
   assign hw_src[VEC_TXP]  = tx_done;
   assign hw_src[VEC_TXC]  = tx_done;
   assign hw_src[VEC_TXA]  = tx_ok_ev_i;
   assign hw_src[VEC_ABA]  = tx_abort_ev_i;

   // Write-one vectors built from the register parts.
   for (genvar v = 0; v < VEC_MASK; v++) begin : g_wdec
      for (genvar p = 0; p < PARTS; p++) begin : g_part
         assign wone[v][p*REG_W +: REG_W] =
            (bus_wr_i && bus_addr_i == ADDR_W'(v*PARTS + p)) ? bus_wdata_i : '0;
      end
   end

   // Each vector gets the storage variant that its access kind needs.
   for (genvar v = 0; v < VEC_MASK; v++) begin : g_vec
      if (v == VEC_TXP || v == VEC_TXC) begin : g_req
         mbx_tx_req_vec #(.W(NUM_MBX)) u_req (
            .clk    (clk),
            .rst_n  (rst_n),
            .req_i  (wone[v]),
            .done_i (hw_src[v]),
            .pend_o (vec_q[v])
         );
      end else begin : g_sticky
         mbx_w1c_vec #(.W(NUM_MBX)) u_flags (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_i   (hw_src[v]),
            .clr_i   (wone[v]),
            .flags_o (vec_q[v])
         );
      end
   end

   // Mask: plain read/write, one part per register.
   for (genvar p = 0; p < PARTS; p++) begin : g_mask
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mask_q[p*REG_W +: REG_W] <= '0;
         else if (bus_wr_i && bus_addr_i == ADDR_W'(VEC_MASK*PARTS + p))
            mask_q[p*REG_W +: REG_W] <= bus_wdata_i;
      end
   end
   assign vec_q[VEC_MASK] = mask_q;

   assign irq_clr = (bus_wr_i && bus_addr_i == ADDR_W'(IRQ_ADDR)) ? bus_wdata_i : '0;

   mbx_irq_flags #(.NUM_MBX(NUM_MBX), .REG_W(REG_W)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .data_ev_i (rx_data_ev_i),
      .rmt_ev_i  (rx_rmt_ev_i),
      .ovr_ev_i  (rx_ovr_ev_i),
      .done_ev_i (tx_done),
      .mask_i    (mask_q),
      .clr_i     (irq_clr),
      .flags_o   (irq_flags),
      .irq_o     (irq_o)
   );

   always_comb begin
      bus_rdata_o = '0;
      for (int v = 0; v < NUM_VEC; v++) begin
         for (int p = 0; p < PARTS; p++) begin
            if (bus_addr_i == ADDR_W'(v*PARTS + p))
               bus_rdata_o = vec_q[v][p*REG_W +: REG_W];
         end
      end
      if (bus_addr_i == ADDR_W'(IRQ_ADDR)) bus_rdata_o = irq_flags;
   end

   // R6: an unmasked data event always raises the interrupt output
   assert_irq_on_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|(rx_data_ev_i & ~mask_q)) |=> irq_o);

   // R7: an abort sets its ack bit whatever the mask holds
   assert_abort_ack_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|(tx_abort_ev_i & mask_q)) |=>
         ((vec_q[VEC_ABA] & $past(tx_abort_ev_i)) == $past(tx_abort_ev_i)));
endmodule

// File: tb/mbx_event_flags_bench.sv
`timescale 1ns/1ps
module mbx_event_flags_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] rx_data, rx_rmt, rx_ovr, tx_ok, tx_abort;
   logic        wr;
   logic [4:0]  addr;
   logic [15:0] wdata;
   logic [15:0] rdata;
   logic        irq;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   logic [31:0] m_vec [8];
   logic [15:0] m_irq;

   always #(CLK_PERIOD/2) clk = ~clk;

   mbx_event_flags u_mbx_event_flags (
      .clk(clk), .rst_n(rst_n),
      .rx_data_ev_i(rx_data), .rx_rmt_ev_i(rx_rmt), .rx_ovr_ev_i(rx_ovr),
      .tx_ok_ev_i(tx_ok), .tx_abort_ev_i(tx_abort),
      .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
      .bus_rdata_o(rdata), .irq_o(irq)
   );

   function automatic string req_of(input int a);
      case (a)
         0, 1:   return "R2 rx-pending";
         2, 3:   return "R3 remote-pending";
         4, 5:   return "R2 unread";
         6, 7:   return "R4 tx-request";
         8, 9:   return "R4 cancel";
         10, 11: return "R5 tx-ack";
         12, 13: return "R5 abort-ack";
         14, 15: return "R10 mask";
         16:     return "R8 irq-flags";
         default: return "R10 reserved";
      endcase
   endfunction

   function automatic logic [15:0] model_read(input int a);
      if (a < 16) return (a % 2) ? m_vec[a/2][31:16] : m_vec[a/2][15:0];
      if (a == 16) return m_irq;
      return 16'h0;
   endfunction

   task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string what);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s: got %h expected %h", what, got, exp);
      end
   endtask

   task automatic rd(input int a, output logic [15:0] v);
      addr = a[4:0];
      #0.2;
      v = rdata;
   endtask

   // Compare every register and irq_o against the model, between edges.
   task automatic check_all(input string tag);
      logic [15:0] v;
      @(negedge clk);
      for (int a = 0; a < 18; a++) begin
         rd(a, v);
         chk(v, model_read(a), {tag, " ", req_of(a)});
      end
      checks++;
      if (irq !== (m_irq != 0)) begin
         failures++;
         $display("FAIL %s R8 irq_o: got %b expected %b", tag, irq, (m_irq != 0));
      end
   endtask

   task automatic step(input logic [31:0] d, r, o, k, ab,
                       input logic w, input int a, input logic [15:0] wd);
      logic [31:0] wone [8];
      logic [15:0] clr, setv;
      logic [31:0] msk;
      for (int v = 0; v < 8; v++)
         wone[v] = (w && a < 16 && a/2 == v) ? ((a % 2) ? {wd, 16'h0} : {16'h0, wd}) : 32'h0;
      msk  = m_vec[7];
      clr  = (w && a == 16) ? wd : 16'h0;
      setv = 16'h0;
      setv[1] = |(d & ~msk);
      setv[2] = |(r & ~msk);
      setv[8] = |((k | ab) & ~msk);
      setv[9] = |(o & ~msk);
      rx_data = d; rx_rmt = r; rx_ovr = o; tx_ok = k; tx_abort = ab;
      wr = w; addr = a[4:0]; wdata = wd;
      @(posedge clk);
      #1;
      m_vec[0] = (m_vec[0] & ~wone[0]) | d;
      m_vec[1] = (m_vec[1] & ~wone[1]) | r;
      m_vec[2] = (m_vec[2] & ~wone[2]) | o;
      m_vec[3] = (m_vec[3] & ~(k | ab)) | wone[3];
      m_vec[4] = (m_vec[4] & ~(k | ab)) | wone[4];
      m_vec[5] = (m_vec[5] & ~wone[5]) | k;
      m_vec[6] = (m_vec[6] & ~wone[6]) | ab;
      if (w && a == 14) m_vec[7][15:0]  = wd;
      if (w && a == 15) m_vec[7][31:16] = wd;
      m_irq = ((m_irq & ~clr) | setv) & 16'h0306;
      rx_data = '0; rx_rmt = '0; rx_ovr = '0; tx_ok = '0; tx_abort = '0;
      wr = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [15:0] v;
      void'($urandom(32'h5eed_c0de));
      rx_data = '0; rx_rmt = '0; rx_ovr = '0; tx_ok = '0; tx_abort = '0;
      wr = 0; addr = 0; wdata = 0;
      for (int i = 0; i < 8; i++) m_vec[i] = '0;
      m_irq = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: every register zero and irq_o low after reset
      check_all("R1 reset");

      // R10/R11: mask mailbox 3 through address 14, read it back
      step('0, '0, '0, '0, '0, 1, 14, 16'h0008);
      @(negedge clk); rd(14, v); chk(v, 16'h0008, "R10 R11 mask readback");

      // R7: masked data event sets status but not irq flag bit 1
      step(32'h8, '0, '0, '0, '0, 0, 0, 0);
      @(negedge clk); rd(0, v); chk(v, 16'h0008, "R7 masked rx-pending set");
      rd(16, v); chk(v, 16'h0000, "R7 masked irq flag clear");
      chk({15'h0, irq}, 16'h0, "R7 irq_o low for masked mailbox");

      // R3/R6: remote frame into mailbox 20 lands at address 3 bit 4
      step('0, 32'h0010_0000, '0, '0, '0, 0, 0, 0);
      @(negedge clk); rd(3, v); chk(v, 16'h0010, "R3 high half remote-pending");
      rd(2, v); chk(v, 16'h0000, "R3 low half untouched");
      rd(16, v); chk(v, 16'h0004, "R6 remote irq flag");

      // R3: writing 0 keeps the bit, writing 1 clears it
      step('0, '0, '0, '0, '0, 1, 3, 16'h0000);
      @(negedge clk); rd(3, v); chk(v, 16'h0010, "R3 write zero no effect");
      step('0, '0, '0, '0, '0, 1, 3, 16'h0010);
      @(negedge clk); rd(3, v); chk(v, 16'h0000, "R3 write one clears");

      // R9: clear of irq bit 2 collides with a new remote event on mailbox 5
      step('0, 32'h20, '0, '0, '0, 1, 16, 16'h0004);
      @(negedge clk); rd(16, v); chk(v, 16'h0004, "R9 set wins over clear");

      // R8: clearing all flags drops irq_o
      step('0, '0, '0, '0, '0, 1, 16, 16'hFFFF);
      @(negedge clk); rd(16, v); chk(v, 16'h0000, "R8 flags cleared");
      chk({15'h0, irq}, 16'h0, "R8 irq_o low when flags clear");

      // R4/R5/R7: request on masked mailbox 3, then success
      step('0, '0, '0, '0, '0, 1, 6, 16'h0008);
      step('0, '0, '0, '0, '0, 1, 8, 16'h0008);
      @(negedge clk); rd(6, v); chk(v, 16'h0008, "R4 request set by write");
      step('0, '0, '0, 32'h8, '0, 0, 0, 0);
      @(negedge clk); rd(6, v); chk(v, 16'h0000, "R4 request cleared on success");
      rd(8, v); chk(v, 16'h0000, "R4 cancel cleared on success");
      rd(10, v); chk(v, 16'h0008, "R5 tx-ack set for masked mailbox");
      rd(16, v); chk(v, 16'h0000, "R7 empty flag blocked by mask");

      // R5/R6: abort on unmasked mailbox 17 raises empty flag
      step('0, '0, '0, '0, '0, 1, 7, 16'h0002);
      step('0, '0, '0, '0, 32'h0002_0000, 0, 0, 0);
      @(negedge clk); rd(13, v); chk(v, 16'h0002, "R5 abort-ack high half");
      rd(7, v); chk(v, 16'h0000, "R4 request cleared on abort");
      rd(16, v); chk(v, 16'h0100, "R6 empty flag on abort");

      // R10: reserved address ignores writes and reads 0
      step('0, '0, '0, '0, '0, 1, 20, 16'hFFFF);
      @(negedge clk); rd(20, v); chk(v, 16'h0000, "R10 reserved address");
      check_all("R11 after directed");

      // Random traffic against the model
      for (int n = 0; n < 400; n++) begin
         logic [31:0] d, r, o, k, ab;
         d  = $urandom & $urandom & $urandom;
         r  = $urandom & $urandom & $urandom;
         o  = $urandom & $urandom & $urandom & $urandom;
         k  = $urandom & $urandom & $urandom;
         ab = $urandom & $urandom & $urandom & $urandom;
         step(d, r, o, k, ab, 1'($urandom % 2), int'($urandom % 20), 16'($urandom));
         check_all("random");
      end

      finish_run();
   end
endmodule